// File: doc/BRIEF.md
# Real-Time Clock Alarm with Repeat Masking

This block is the alarm part of a BCD real-time clock. Software writes four alarm bytes: seconds, minutes, hours and day of month. Bit 7 of each byte is a repeat-mask bit. A timekeeping section outside this block provides a one-second strobe and the current BCD time fields. On each strobe the block compares the alarm against the time and produces a one-cycle interrupt pulse when they match.

The pattern of the four mask bits sets the repeat period: monthly, daily, hourly, every minute or every second. A field whose mask bit is set is ignored in the comparison. Writes that do not hold a valid BCD value for their field are dropped, so a stored field always holds a value that the time can actually reach.

A small sequencer runs the interrupt timing. Its states are `SQ_IDLE`, `SQ_EVAL` and `SQ_PULSE`:

- `SQ_IDLE` goes to `SQ_EVAL` on a strobe and latches the compare result.
- `SQ_EVAL` goes to `SQ_PULSE` if that result was a hit, and back to `SQ_IDLE` otherwise.
- `SQ_PULSE` drives the interrupt for one cycle and then returns to `SQ_IDLE`.

Strobes are assumed to be at least three clock cycles apart.

Top module: `rtc_alarm_unit`

## Requirements
- R1: The register index selects the field: 0 is seconds, 1 is minutes, 2 is hours and 3 is day of month. `rdata` shows, in the same cycle, the full stored byte at `addr`, including bit 7.
- R2: A write to seconds or minutes is stored only if bits 6:4 (tens) and bits 3:0 (units) form a BCD value from 0 to 59 with units no greater than 9. Any other write leaves the register unchanged.
- R3: A write to hours is stored only if bits 5:4 (tens) and bits 3:0 (units) form a BCD value from 0 to 23 with units no greater than 9. Any other write leaves the register unchanged.
- R4: A write to day is stored only if bit 4 (tens) and bits 3:0 (units) form a BCD value from 1 to 19 with units no greater than 9. Any other write leaves the register unchanged.
- R5: Synchronous active-high reset clears all four registers to 0x00 and holds `irq` low.
- R6: With all four mask bits clear, a strobe gives a hit only when all four fields are equal. The fields compared are seconds [6:0], minutes [6:0], hours [5:0] and day [4:0].
- R7: With only the day mask set, a hit needs seconds, minutes and hours to be equal; day is ignored.
- R8: With only the day and hour masks set, a hit needs seconds and minutes to be equal.
- R9: With the day, hour and minute masks set and the seconds mask clear, a hit needs seconds to be equal.
- R10: Any other mask pattern, including every pattern with the seconds mask set, gives a hit on every strobe.
- R11: A hit at a strobe sampled at clock edge N raises `irq` after edge N+1 for exactly one cycle. Without a strobe, `irq` stays low.
- R12: When a write and a strobe fall in the same cycle, the compare uses the alarm value stored before that write. The new value applies from the next strobe on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Alarm register index |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Stored byte at `addr` |
| tick | input | 1 | One-second strobe |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_day | input | 8 | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
A register write and a one-second strobe can fall in the same clock cycle. That makes the compare race against the alarm update. The bench raises `wr_en` and `tick` in the same cycle, both in directed cases and at random. It then expects the pulse, or its absence, that follows from the alarm bytes as they stood before the write. The next strobe is judged against the new value.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int FIELD_CNT = 4;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = $clog2(FIELD_CNT);
    localparam int MASK_BIT  = DATA_W - 1;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;

    typedef enum logic [1:0] {SQ_IDLE, SQ_EVAL, SQ_PULSE} seq_state_t;
    typedef enum logic [2:0] {RP_MONTH, RP_DAY, RP_HOUR, RP_MIN, RP_SEC} repeat_t;

    typedef logic [FIELD_CNT-1:0][DATA_W-1:0] alarm_bank_t;

    function automatic logic bcd_in_range(input logic [3:0] tens, input logic [3:0] units,
                                          input int lo, input int hi);
        int v;
        v = int'(tens) * 10 + int'(units);
        return (units <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

    function automatic logic field_ok(input logic [IDX_W-1:0] idx, input logic [DATA_W-1:0] v);
        logic ok;
        unique case (int'(idx))
            F_SEC, F_MIN: ok = bcd_in_range({1'b0, v[6:4]}, v[3:0], 0, 59);
            F_HOUR:       ok = bcd_in_range({2'b00, v[5:4]}, v[3:0], 0, 23);
            default:      ok = bcd_in_range({3'b000, v[4]}, v[3:0], 1, 19);
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output alarm_bank_t       alarm_q
);
    for (genvar g = 0; g < FIELD_CNT; g++) begin : g_field
        logic hit_wr;
        assign hit_wr = wr_en && (addr == IDX_W'(g)) && field_ok(IDX_W'(g), wdata);
        always_ff @(posedge clk) begin
            if (rst)
                alarm_q[g] <= '0;
            else if (hit_wr)
                alarm_q[g] <= wdata;
        end
    end

    assign rdata = alarm_q[addr];
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  alarm_bank_t       alarm_q,
    input  logic [DATA_W-1:0] now_sec,
    input  logic [DATA_W-1:0] now_min,
    input  logic [DATA_W-1:0] now_hour,
    input  logic [DATA_W-1:0] now_day,
    output repeat_t           period,
    output logic              hit
);
    logic [FIELD_CNT-1:0] mask;
    logic sec_eq, min_eq, hour_eq, day_eq;

    for (genvar g = 0; g < FIELD_CNT; g++) begin : g_mask
        assign mask[g] = alarm_q[g][MASK_BIT];
    end

    assign sec_eq  = alarm_q[F_SEC][6:0]  == now_sec[6:0];
    assign min_eq  = alarm_q[F_MIN][6:0]  == now_min[6:0];
    assign hour_eq = alarm_q[F_HOUR][5:0] == now_hour[5:0];
    assign day_eq  = alarm_q[F_DAY][4:0]  == now_day[4:0];

    always_comb begin
        unique case (mask)
            4'b0000: period = RP_MONTH;
            4'b1000: period = RP_DAY;
            4'b1100: period = RP_HOUR;
            4'b1110: period = RP_MIN;
            default: period = RP_SEC;
        endcase
    end

    always_comb begin
        unique case (period)
            RP_MONTH: hit = sec_eq && min_eq && hour_eq && day_eq;
            RP_DAY:   hit = sec_eq && min_eq && hour_eq;
            RP_HOUR:  hit = sec_eq && min_eq;
            RP_MIN:   hit = sec_eq;
            default:  hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/rtc_alarm_seq.sv
module rtc_alarm_seq
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    output logic irq
);
    seq_state_t state_q, state_d;
    logic       hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_IDLE && tick)
                hit_q <= hit;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (tick) state_d = SQ_EVAL;
            SQ_EVAL:  state_d = hit_q ? SQ_PULSE : SQ_IDLE;
            SQ_PULSE: state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == SQ_PULSE);
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    input  logic [DATA_W-1:0] now_sec,
    input  logic [DATA_W-1:0] now_min,
    input  logic [DATA_W-1:0] now_hour,
    input  logic [DATA_W-1:0] now_day,
    output logic              irq
);
    alarm_bank_t alarm_q;
    repeat_t     period;
    logic        hit;

    rtc_alarm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .alarm_q(alarm_q)
    );

    rtc_alarm_match u_match (
        .alarm_q(alarm_q), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_day(now_day), .period(period), .hit(hit)
    );

    rtc_alarm_seq u_seq (
        .clk(clk), .rst(rst), .tick(tick), .hit(hit), .irq(irq)
    );
endmodule

// File: rtl/rtc_alarm_unit_chk.sv
module rtc_alarm_unit_chk
    import rtc_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [IDX_W-1:0]  addr,
    input logic [DATA_W-1:0] wdata,
    input logic              tick,
    input alarm_bank_t       alarm_q,
    input logic              irq
);
    p_reset_quiet_r5: assert property (@(posedge clk) rst |=> (!irq && alarm_q == '0));

    p_drop_bad_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !field_ok(addr, wdata)) |=> $stable(alarm_q));

    p_keep_good_write_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && field_ok(addr, wdata)) |=> alarm_q[$past(addr)] == $past(wdata));

    p_pulse_single_r11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_pulse_needs_tick_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick, 2));

    p_sec_mask_fires_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && alarm_q[F_SEC][MASK_BIT] && !$past(tick) && !$past(tick, 2)) |-> ##2 irq);
endmodule

bind rtc_alarm_unit rtc_alarm_unit_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tick(tick), .alarm_q(alarm_q), .irq(irq)
);

// File: tb/rtc_alarm_unit_test.sv
`timescale 1ns/1ps
module rtc_alarm_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_day = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [4];

    always #2.5 clk = ~clk;

    rtc_alarm_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick(tick), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_day(now_day), .irq(irq)
    );

    function automatic bit exp_ok(input int idx, input logic [7:0] v);
        int t, u;
        u = int'(v[3:0]);
        if (idx <= 1) t = int'(v[6:4]);
        else if (idx == 2) t = int'(v[5:4]);
        else t = int'(v[4]);
        if (u > 9) return 0;
        if (idx <= 1) return (t * 10 + u) <= 59;
        if (idx == 2) return (t * 10 + u) <= 23;
        return (t * 10 + u) >= 1;
    endfunction

    function automatic bit exp_hit(input logic [7:0] s, input logic [7:0] m,
                                   input logic [7:0] h, input logic [7:0] d);
        bit es, em, eh, ed;
        es = mdl[0][6:0] == s[6:0];
        em = mdl[1][6:0] == m[6:0];
        eh = mdl[2][5:0] == h[5:0];
        ed = mdl[3][4:0] == d[4:0];
        case ({mdl[3][7], mdl[2][7], mdl[1][7], mdl[0][7]})
            4'b0000: return es & em & eh & ed;
            4'b1000: return es & em & eh;
            4'b1100: return es & em;
            4'b1110: return es;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'(idx); wdata = v;
        if (exp_ok(idx, v)) mdl[idx] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, input string req);
        addr = 2'(idx);
        #1;
        chk(rdata == mdl[idx], req, int'(rdata), int'(mdl[idx]));
    endtask

    task automatic tk(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input logic [7:0] d, input string req,
                      input bit do_wr, input int idx, input logic [7:0] v);
        bit e;
        @(negedge clk);
        now_sec = s; now_min = m; now_hour = h; now_day = d;
        tick = 1'b1;
        e = exp_hit(s, m, h, d);
        if (do_wr) begin
            wr_en = 1'b1; addr = 2'(idx); wdata = v;
            if (exp_ok(idx, v)) mdl[idx] = v;
        end
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk(irq == 1'b0, {req, " early"}, int'(irq), 0);
        @(negedge clk);
        chk(irq == e, req, int'(irq), int'(e));
        @(negedge clk);
        chk(irq == 1'b0, {req, " width R11"}, int'(irq), 0);
    endtask

    function automatic logic [7:0] rnd_val(input int idx);
        logic [7:0] v;
        if ($urandom % 4 == 0) return 8'($urandom);
        case (idx)
            0, 1: v = {1'b0, 3'($urandom % 6), 4'($urandom % 10)};
            2:    v = {2'b00, 2'($urandom % 3), 4'($urandom % 4)};
            default: v = {3'b000, 1'($urandom % 2), 4'(1 + $urandom % 9)};
        endcase
        v[7] = ($urandom % 3 == 0);
        return v;
    endfunction

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R5: reset state
        for (int i = 0; i < 4; i++) rd(i, "R5 reset reg");
        chk(irq == 1'b0, "R5 reset irq", int'(irq), 0);

        // R2 seconds/minutes limits
        wr(0, 8'h59); rd(0, "R2 sec 59");
        wr(0, 8'h60); rd(0, "R2 sec 60 dropped");
        wr(1, 8'h4A); rd(1, "R2 min bad digit");
        wr(1, 8'hB7); rd(1, "R2 R1 min with mask");
        // R3 hours
        wr(2, 8'h23); rd(2, "R3 hour 23");
        wr(2, 8'h24); rd(2, "R3 hour 24 dropped");
        // R4 day
        wr(3, 8'h00); rd(3, "R4 day 0 dropped");
        wr(3, 8'h19); rd(3, "R4 day 19");
        wr(3, 8'h1A); rd(3, "R4 day bad digit");

        // R6 monthly
        wr(0, 8'h10); wr(1, 8'h20); wr(2, 8'h05); wr(3, 8'h07);
        tk(8'h10, 8'h20, 8'h05, 8'h07, "R6 month hit", 0, 0, 0);
        tk(8'h10, 8'h20, 8'h05, 8'h08, "R6 month day miss", 0, 0, 0);
        // R7 daily
        wr(3, 8'h87);
        tk(8'h10, 8'h20, 8'h05, 8'h12, "R7 day hit", 0, 0, 0);
        tk(8'h10, 8'h20, 8'h06, 8'h07, "R7 hour miss", 0, 0, 0);
        // R8 hourly
        wr(2, 8'h85);
        tk(8'h10, 8'h20, 8'h11, 8'h02, "R8 hour hit", 0, 0, 0);
        tk(8'h10, 8'h21, 8'h05, 8'h07, "R8 min miss", 0, 0, 0);
        // R9 minutely
        wr(1, 8'hA0);
        tk(8'h10, 8'h33, 8'h11, 8'h02, "R9 min hit", 0, 0, 0);
        tk(8'h11, 8'h20, 8'h05, 8'h07, "R9 sec miss", 0, 0, 0);
        // R10 other patterns
        wr(0, 8'h90);
        tk(8'h44, 8'h01, 8'h02, 8'h03, "R10 all masked", 0, 0, 0);
        wr(1, 8'h20); wr(2, 8'h05); wr(3, 8'h07); wr(0, 8'h10);
        wr(2, 8'h85);
        tk(8'h44, 8'h01, 8'h02, 8'h03, "R10 hour-only mask", 0, 0, 0);
        wr(2, 8'h05);
        // R11: no tick, no pulse
        repeat (4) begin
            @(negedge clk);
            chk(irq == 1'b0, "R11 idle", int'(irq), 0);
        end
        // R12: write with tick uses old value
        wr(0, 8'h90);
        tk(8'h00, 8'h00, 8'h00, 8'h01, "R12 old mask used", 1, 0, 8'h30);
        tk(8'h00, 8'h00, 8'h00, 8'h01, "R12 new value applies", 0, 0, 0);
        tk(8'h30, 8'h20, 8'h05, 8'h07, "R12 new value hit", 1, 0, 8'h15);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) begin
                int idx;
                idx = int'($urandom % 4);
                wr(idx, rnd_val(idx));
                rd(idx, "R1 R2 R3 R4 random write");
            end else begin
                logic [7:0] s, m, h, d;
                s = ($urandom % 2) ? {1'b0, mdl[0][6:0]} : {1'b0, 3'($urandom % 6), 4'($urandom % 10)};
                m = ($urandom % 2) ? {1'b0, mdl[1][6:0]} : {1'b0, 3'($urandom % 6), 4'($urandom % 10)};
                h = ($urandom % 2) ? {2'b00, mdl[2][5:0]} : {2'b00, 2'($urandom % 3), 4'($urandom % 4)};
                d = ($urandom % 2) ? {3'b000, mdl[3][4:0]} : {3'b000, 1'($urandom % 2), 4'($urandom % 10)};
                if (op == 2) begin
                    int idx;
                    idx = int'($urandom % 4);
                    tk(s, m, h, d, "R12 random tick+write", 1, idx, rnd_val(idx));
                end else begin
                    tk(s, m, h, d, "R6 R7 R8 R9 R10 random tick", 0, 0, 0);
                end
            end
        end
        for (int i = 0; i < 4; i++) rd(i, "R1 final readback");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule